// File: doc/BRIEF.md
# Interrupt Affinity Routing Cache

This block keeps a lookup table that gives, for each shared interrupt, the index of the processor that the interrupt is routed to. Each shared interrupt has a 64-bit routing word, and each processor has a 64-bit type word whose upper half carries its affinity. The block compares a target affinity taken from the routing word against the processors' affinities. It stores the result as a processor index with a valid flag, so that delivery logic can read the target in the same cycle instead of searching for it.

Updates are serial. A scan tests one processor per clock in ascending index order and stops at the first match. A single-interrupt update rescans one interrupt. A full rebuild walks every shared interrupt in turn. Writing a routing word queues a single-interrupt update for that interrupt on its own. A change to a type word only takes effect once software asks for an update or a rebuild. Updates that arrive while a rebuild is running are held in a pending set. They are served after the rebuild, except for any interrupt that the rebuild has not yet reached, since the rebuild covers it.

Top module: `arc_affinity_cache`

## Requirements
- R1: The target affinity of an interrupt is 32 bits. Its bits [31:24] are routing-word bits [39:32] and its bits [23:0] are routing-word bits [23:0]. The affinity of a processor is bits [63:32] of its type word. All other bits of both words have no effect on the result.
- R2: Processors are compared in ascending index order, and the lowest-indexed processor whose affinity equals the target is stored. When several processors share an affinity, the lowest index wins.
- R3: If no processor matches, the entry is stored invalid. An invalid entry reads as rdValid=0 and rdCpu=0.
- R4: A scan tests one processor per clock. A single update requested in cycle 0 on an idle block raises done in cycle k+3, where k is the index of the matching processor. With no match, done rises in cycle NUM_CPU+2.
- R5: busy is high while a scan is running. done is a one-cycle pulse, raised while busy is low, when a request finishes.
- R6: While reset is held, every entry reads invalid. After reset is released, a full rebuild starts without any request, and busy is high from the second clock edge.
- R7: A pulse on rebuildReq rescans every shared ID from 32 to NUM_IRQ-1 using the routing and type words present at that time.
- R8: A write to the routing word of a shared ID queues a single update for that ID. After the block is idle, the entry reflects the new word.
- R9: A write to a processor's type word does not change any entry by itself.
- R10: A single update that arrives during a rebuild is held and is not lost. When the block is idle again, every entry matches the current routing and type words, including IDs whose routing word changed after the rebuild had passed them.
- R11: Reads of IDs below 32 or at NUM_IRQ and above return invalid. Update requests for IDs below 32 start no scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| routeWrEn | input | 1 | Write strobe for a routing word |
| routeWrIrq | input | IRQ_W | Interrupt ID of the routing word to write |
| routeWrData | input | 64 | New routing word |
| typeWrEn | input | 1 | Write strobe for a processor type word |
| typeWrCpu | input | CPU_W | Processor index of the type word to write |
| typeWrData | input | 64 | New type word |
| updReq | input | 1 | Request a rescan of one interrupt |
| updIrq | input | IRQ_W | Interrupt ID for updReq |
| rebuildReq | input | 1 | Request a rescan of all shared interrupts |
| rdIrq | input | IRQ_W | Interrupt ID to look up |
| rdValid | output | 1 | The looked-up interrupt has a target |
| rdCpu | output | CPU_W | Target processor index (0 when invalid) |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when a request finishes |

## Verification
The bench gives two processors the same affinity. A design that stops at the last match instead of the first, or that compares in the wrong order, would store the wrong processor index. Routing words carry nonzero bits outside the two affinity fields, so a design that takes the wrong bits would miss or falsely hit. The bench changes routing words after a rebuild has already passed them and expects the final table to be current, which catches a design that drops held updates. It also writes type words without asking for a rescan and expects stale entries, which catches a design that updates on its own. Cycle counts for a single update, taken at several match positions and with no match, catch a design that scans more than one processor per clock, adds a stage, or does not stop at the first match.

// File: rtl/arc_pkg.sv
package arc_pkg;

  // First interrupt ID that the cache covers; IDs below are private
  localparam int SHARED_BASE = 32;
  localparam int AFF_W = 32;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } arcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTgt;   // capture target affinity of tgtIdx
    logic wrEntry;   // write result for curIdx
    logic entryHit;  // result is a match at cpuIdx
  } arcStrobe_t;

  // Target affinity: high byte from bits 39:32, low three bytes from 23:0
  function automatic logic [AFF_W-1:0] routeAff(input logic [63:0] w);
    return {w[39:32], w[23:0]};
  endfunction

  function automatic logic [AFF_W-1:0] typeAff(input logic [63:0] w);
    return w[63:32];
  endfunction

endpackage

// File: rtl/arc_control.sv
module arc_control
  import arc_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int NUM_SHARED = NUM_IRQ - SHARED_BASE,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IRQ_W = $clog2(NUM_IRQ),
  localparam int SH_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             routeWrEn,
  input  logic [IRQ_W-1:0] routeWrIrq,
  input  logic             updReq,
  input  logic [IRQ_W-1:0] updIrq,
  input  logic             rebuildReq,
  input  logic             cmpMatch,
  output arcStrobe_t       strobe,
  output logic [SH_W-1:0]  tgtIdx,
  output logic [SH_W-1:0]  curIdx,
  output logic [CPU_W-1:0] cpuIdx,
  output logic             busy,
  output logic             done
);

  arcState_t state;
  logic inRebuild;
  logic rebuildPend;
  logic doneQ;
  logic [NUM_SHARED-1:0] pend;
  logic [NUM_SHARED-1:0] setMask;
  logic [NUM_SHARED-1:0] clrMask;
  logic [SH_W-1:0] lowIdx;
  logic routeShared, updShared;
  logic [SH_W-1:0] routeSh, updSh;
  logic startRebuild, startSingle, finishIrq, lastIrq, lastCpu, continueRebuild;

  assign routeShared = (int'(routeWrIrq) >= SHARED_BASE) && (int'(routeWrIrq) < NUM_IRQ);
  assign updShared   = (int'(updIrq) >= SHARED_BASE) && (int'(updIrq) < NUM_IRQ);
  assign routeSh = SH_W'(routeWrIrq - IRQ_W'(SHARED_BASE));
  assign updSh   = SH_W'(updIrq - IRQ_W'(SHARED_BASE));

  // New requests for the pending set
  always_comb begin
    setMask = '0;
    if (routeWrEn && routeShared) setMask[routeSh] = 1'b1;
    if (updReq && updShared) setMask[updSh] = 1'b1;
  end

  // Lowest pending interrupt is served first
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_SHARED - 1; i >= 0; i--) begin
      if (pend[i]) lowIdx = SH_W'(i);
    end
  end

  assign lastCpu = (cpuIdx == CPU_W'(NUM_CPU - 1));
  assign lastIrq = (curIdx == SH_W'(NUM_SHARED - 1));
  assign startRebuild = (state == ST_IDLE) && rebuildPend;
  assign startSingle = (state == ST_IDLE) && !rebuildPend && (|pend);
  assign finishIrq = (state == ST_SCAN) && (cmpMatch || lastCpu);
  assign continueRebuild = finishIrq && inRebuild && !lastIrq;

  always_comb begin
    strobe.loadTgt = startRebuild || startSingle || continueRebuild;
    strobe.wrEntry = finishIrq;
    strobe.entryHit = cmpMatch;
    if (state == ST_IDLE) tgtIdx = startRebuild ? '0 : lowIdx;
    else tgtIdx = SH_W'(curIdx + 1);
    clrMask = '0;
    if (strobe.loadTgt) clrMask[tgtIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      inRebuild <= 1'b0;
      rebuildPend <= 1'b1;   // a rebuild always follows reset
      pend <= '0;
      curIdx <= '0;
      cpuIdx <= '0;
      doneQ <= 1'b0;
    end else begin
      pend <= (pend & ~clrMask) | setMask;
      rebuildPend <= (rebuildPend && !startRebuild) || rebuildReq;
      doneQ <= finishIrq && !continueRebuild;
      if (strobe.loadTgt) begin
        state <= ST_SCAN;
        curIdx <= tgtIdx;
        cpuIdx <= '0;
        if (state == ST_IDLE) inRebuild <= startRebuild;
      end else if (finishIrq) begin
        state <= ST_IDLE;
      end else if (state == ST_SCAN) begin
        cpuIdx <= CPU_W'(cpuIdx + 1);
      end
    end
  end

  assign busy = (state == ST_SCAN);
  assign done = doneQ;

endmodule

// File: rtl/arc_datapath.sv
module arc_datapath
  import arc_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int NUM_SHARED = NUM_IRQ - SHARED_BASE,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IRQ_W = $clog2(NUM_IRQ),
  localparam int SH_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             routeWrEn,
  input  logic [IRQ_W-1:0] routeWrIrq,
  input  logic [63:0]      routeWrData,
  input  logic             typeWrEn,
  input  logic [CPU_W-1:0] typeWrCpu,
  input  logic [63:0]      typeWrData,
  input  arcStrobe_t       strobe,
  input  logic [SH_W-1:0]  tgtIdx,
  input  logic [SH_W-1:0]  curIdx,
  input  logic [CPU_W-1:0] cpuIdx,
  output logic             cmpMatch,
  input  logic [IRQ_W-1:0] rdIrq,
  output logic             rdValid,
  output logic [CPU_W-1:0] rdCpu
);

  // Only the affinity fields are stored; other bits never reach a result
  logic [AFF_W-1:0] irqAff [NUM_SHARED];
  logic [AFF_W-1:0] cpuAff [NUM_CPU];
  logic             entValid [NUM_SHARED];
  logic [CPU_W-1:0] entCpu [NUM_SHARED];
  logic [AFF_W-1:0] tgtAff;
  logic [AFF_W-1:0] newRouteAff, newTypeAff;
  logic routeShared, rdShared;
  logic [SH_W-1:0] routeSh, rdSh;
  logic unusedBits;

  assign newRouteAff = routeAff(routeWrData);
  assign newTypeAff = typeAff(typeWrData);
  assign unusedBits = ^{routeWrData[63:40], routeWrData[31:24], typeWrData[31:0]};

  assign routeShared = (int'(routeWrIrq) >= SHARED_BASE) && (int'(routeWrIrq) < NUM_IRQ);
  assign routeSh = SH_W'(routeWrIrq - IRQ_W'(SHARED_BASE));

  for (genvar g = 0; g < NUM_SHARED; g++) begin : gIrq
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqAff[g] <= '0;
      else if (routeWrEn && routeShared && (routeSh == SH_W'(g))) irqAff[g] <= newRouteAff;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entCpu[g] <= '0;
      end else if (strobe.wrEntry && (curIdx == SH_W'(g))) begin
        entValid[g] <= strobe.entryHit;
        entCpu[g] <= strobe.entryHit ? cpuIdx : '0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cpuAff[c] <= '0;
      else if (typeWrEn && (typeWrCpu == CPU_W'(c))) cpuAff[c] <= newTypeAff;
    end
  end

  // Target held for the whole scan of one interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tgtAff <= '0;
    else if (strobe.loadTgt) tgtAff <= irqAff[tgtIdx];
  end

  assign cmpMatch = (cpuAff[cpuIdx] == tgtAff);

  assign rdShared = (int'(rdIrq) >= SHARED_BASE) && (int'(rdIrq) < NUM_IRQ);
  assign rdSh = SH_W'(rdIrq - IRQ_W'(SHARED_BASE));
  assign rdValid = rdShared && entValid[rdSh];
  assign rdCpu = rdShared ? entCpu[rdSh] : '0;

endmodule

// File: rtl/arc_affinity_cache.sv
module arc_affinity_cache
  import arc_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int NUM_SHARED = NUM_IRQ - SHARED_BASE,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IRQ_W = $clog2(NUM_IRQ),
  localparam int SH_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             routeWrEn,
  input  logic [IRQ_W-1:0] routeWrIrq,
  input  logic [63:0]      routeWrData,
  input  logic             typeWrEn,
  input  logic [CPU_W-1:0] typeWrCpu,
  input  logic [63:0]      typeWrData,
  input  logic             updReq,
  input  logic [IRQ_W-1:0] updIrq,
  input  logic             rebuildReq,
  input  logic [IRQ_W-1:0] rdIrq,
  output logic             rdValid,
  output logic [CPU_W-1:0] rdCpu,
  output logic             busy,
  output logic             done
);

  arcStrobe_t strobe;
  logic [SH_W-1:0] tgtIdx;
  logic [SH_W-1:0] curIdx;
  logic [CPU_W-1:0] cpuIdx;
  logic cmpMatch;

  arc_control #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_ctl (
    .clk(clk), .rstN(rstN),
    .routeWrEn(routeWrEn), .routeWrIrq(routeWrIrq),
    .updReq(updReq), .updIrq(updIrq), .rebuildReq(rebuildReq),
    .cmpMatch(cmpMatch), .strobe(strobe),
    .tgtIdx(tgtIdx), .curIdx(curIdx), .cpuIdx(cpuIdx),
    .busy(busy), .done(done)
  );

  arc_datapath #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN),
    .routeWrEn(routeWrEn), .routeWrIrq(routeWrIrq), .routeWrData(routeWrData),
    .typeWrEn(typeWrEn), .typeWrCpu(typeWrCpu), .typeWrData(typeWrData),
    .strobe(strobe), .tgtIdx(tgtIdx), .curIdx(curIdx), .cpuIdx(cpuIdx),
    .cmpMatch(cmpMatch),
    .rdIrq(rdIrq), .rdValid(rdValid), .rdCpu(rdCpu)
  );

endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
  parameter int NUM_CPU = 4,
  parameter int NUM_IRQ = 64,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IRQ_W = $clog2(NUM_IRQ)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic [IRQ_W-1:0] rdIrq,
  input logic             rdValid,
  input logic [CPU_W-1:0] cpuIdx,
  input logic             wrEntry
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R6: rebuild begins by itself after reset
  assert_rebuild_after_reset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd1) |-> busy);

  // R5: done only directly after a scan, with busy low
  assert_done_after_scan_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R5: done lasts one cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: one processor per clock while an interrupt is scanned
  assert_one_cpu_per_clock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(wrEntry)) |-> (cpuIdx == CPU_W'($past(cpuIdx) + 1)));

  // R2: scan index stays inside the processor list
  assert_cpu_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(cpuIdx) < NUM_CPU));

  // R11: private IDs are never reported valid
  assert_private_invalid_R11: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdIrq) < 32) |-> !rdValid);

endmodule

bind arc_affinity_cache arc_checker #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .rdIrq(rdIrq), .rdValid(rdValid), .cpuIdx(cpuIdx), .wrEntry(strobe.wrEntry)
);

// File: tb/tb_arc_affinity_cache.sv
`timescale 1ns/1ps
module tb_arc_affinity_cache;

  localparam int NUM_CPU = 4;
  localparam int NUM_IRQ = 64;
  localparam int CPU_W = 2;
  localparam int IRQ_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic routeWrEn = 1'b0;
  logic [IRQ_W-1:0] routeWrIrq = '0;
  logic [63:0] routeWrData = '0;
  logic typeWrEn = 1'b0;
  logic [CPU_W-1:0] typeWrCpu = '0;
  logic [63:0] typeWrData = '0;
  logic updReq = 1'b0;
  logic [IRQ_W-1:0] updIrq = '0;
  logic rebuildReq = 1'b0;
  logic [IRQ_W-1:0] rdIrq = '0;
  logic rdValid;
  logic [CPU_W-1:0] rdCpu;
  logic busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Reference state
  logic [63:0] mRoute [NUM_IRQ];
  logic [63:0] mType [NUM_CPU];
  logic expValid [NUM_IRQ];
  logic [CPU_W-1:0] expCpu [NUM_IRQ];

  localparam logic [31:0] AFF_A = 32'h0001_0203;
  localparam logic [31:0] AFF_B = 32'h0A00_0011;
  localparam logic [31:0] AFF_C = 32'h7F12_3456;
  localparam logic [31:0] AFF_D = 32'h5555_0000;

  always #10 clk = ~clk;

  arc_affinity_cache #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) dut (
    .clk(clk), .rstN(rstN),
    .routeWrEn(routeWrEn), .routeWrIrq(routeWrIrq), .routeWrData(routeWrData),
    .typeWrEn(typeWrEn), .typeWrCpu(typeWrCpu), .typeWrData(typeWrData),
    .updReq(updReq), .updIrq(updIrq), .rebuildReq(rebuildReq),
    .rdIrq(rdIrq), .rdValid(rdValid), .rdCpu(rdCpu),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CPU_W:0] firstMatch(input int irq);
    logic [31:0] tgt;
    tgt = {mRoute[irq][39:32], mRoute[irq][23:0]};
    for (int c = 0; c < NUM_CPU; c++) begin
      if (mType[c][63:32] == tgt) return {1'b1, CPU_W'(c)};
    end
    return '0;
  endfunction

  task automatic recalc(input int irq);
    logic [CPU_W:0] r;
    r = firstMatch(irq);
    expValid[irq] = r[CPU_W];
    expCpu[irq] = r[CPU_W-1:0];
  endtask

  function automatic logic [63:0] mkRoute(input logic [31:0] aff, input logic [7:0] junk);
    return {16'hC3C3, junk, aff[31:24], junk ^ 8'h5A, aff[23:0]};
  endfunction

  task automatic writeRoute(input int irq, input logic [63:0] data);
    routeWrEn = 1'b1; routeWrIrq = IRQ_W'(irq); routeWrData = data;
    @(negedge clk);
    routeWrEn = 1'b0;
    mRoute[irq] = data;
    if (irq >= 32) recalc(irq);
  endtask

  task automatic writeType(input int cpu, input logic [31:0] aff, input logic [31:0] low);
    typeWrEn = 1'b1; typeWrCpu = CPU_W'(cpu); typeWrData = {aff, low};
    @(negedge clk);
    typeWrEn = 1'b0;
    mType[cpu] = {aff, low};
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic readChk(input int irq, input string req);
    rdIrq = IRQ_W'(irq);
    #1;
    chk(req, $sformatf("valid irq %0d", irq), 64'(rdValid), 64'(expValid[irq]));
    chk(req, $sformatf("cpu irq %0d", irq), 64'(rdCpu), 64'(expCpu[irq]));
  endtask

  task automatic compareAll(input string req);
    for (int i = 0; i < NUM_IRQ; i++) readChk(i, req);
  endtask

  // Cycles from request to done pulse; also checks the pulse width
  task automatic measure(input int irq, input int expN, input string req);
    int n;
    updReq = 1'b1; updIrq = IRQ_W'(irq);
    @(negedge clk);
    updReq = 1'b0;
    n = 1;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, $sformatf("latency irq %0d", irq), 64'(n), 64'(expN));
    @(negedge clk);
    chk("R5", "done width", 64'(done), 64'd0);
  endtask

  // Per-clock monitor: done and busy are never high together
  always @(negedge clk) begin
    if (rstN && done) begin
      checks++;
      if (busy) begin
        failures++;
        $display("FAIL R5 done with busy actual=1 expected=0");
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      mRoute[i] = '0; expValid[i] = 1'b0; expCpu[i] = '0;
    end
    for (int c = 0; c < NUM_CPU; c++) mType[c] = '0;

    // R6: reset state
    repeat (3) @(negedge clk);
    rdIrq = 6'd40; #1;
    chk("R6", "valid in reset", 64'(rdValid), 64'd0);
    chk("R6", "busy in reset", 64'(busy), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R6", "busy after reset", 64'(busy), 64'd1);
    for (int i = 32; i < NUM_IRQ; i++) recalc(i);
    waitIdle();
    compareAll("R6");

    // Processor affinities; cpu1 and cpu2 share one
    writeType(0, AFF_A, 32'hDEAD_0000);
    writeType(1, AFF_B, 32'h0000_0001);
    writeType(2, AFF_B, 32'h0000_0002);
    writeType(3, AFF_C, 32'h0000_0003);
    waitIdle();
    // R9: entries untouched by type writes
    readChk(40, "R9");
    readChk(50, "R9");

    // R8 and R1: routing writes trigger their own updates
    writeRoute(32, mkRoute(AFF_B, 8'hE1));
    writeRoute(33, mkRoute(AFF_C, 8'h3C));
    writeRoute(34, mkRoute(AFF_D, 8'hFF));
    writeRoute(35, mkRoute(AFF_A, 8'h81));
    writeRoute(10, mkRoute(AFF_C, 8'h00));
    waitIdle();
    readChk(32, "R2");
    readChk(34, "R3");
    readChk(35, "R1");
    readChk(10, "R11");
    compareAll("R8");

    // R4: latency by match position
    measure(35, 3, "R4");
    measure(32, 4, "R4");
    measure(33, 6, "R4");
    measure(34, NUM_CPU + 2, "R4");

    // R11: private update starts nothing
    updReq = 1'b1; updIrq = 6'd7;
    @(negedge clk);
    updReq = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11", "busy after private update", 64'(busy), 64'd0);
    end

    // R7: full rebuild picks up every routing and type word
    for (int i = 40; i < NUM_IRQ; i++) begin
      case (i % 4)
        0: writeRoute(i, mkRoute(AFF_A, 8'(i)));
        1: writeRoute(i, mkRoute(AFF_B, 8'(i)));
        2: writeRoute(i, mkRoute(AFF_C, 8'(i)));
        default: writeRoute(i, mkRoute(AFF_D, 8'(i)));
      endcase
    end
    waitIdle();
    writeType(0, AFF_C, 32'h1111_1111);
    writeType(3, AFF_A, 32'h2222_2222);
    waitIdle();
    rebuildReq = 1'b1;
    @(negedge clk);
    rebuildReq = 1'b0;
    for (int i = 32; i < NUM_IRQ; i++) recalc(i);
    waitIdle();
    compareAll("R7");

    // R10: routing changes during a rebuild, before and after its position
    rebuildReq = 1'b1;
    @(negedge clk);
    rebuildReq = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10", "busy mid rebuild", 64'(busy), 64'd1);
    writeRoute(33, mkRoute(AFF_A, 8'h77));
    writeRoute(62, mkRoute(AFF_B, 8'h66));
    writeRoute(32, mkRoute(AFF_D, 8'h55));
    for (int i = 32; i < NUM_IRQ; i++) recalc(i);
    waitIdle();
    compareAll("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule